// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is one 16-bit down-counting channel of a three-channel interval timer, together with the decoder for the control byte that the three channels share. Software reaches the counter through an 8-bit data port. A value is always written and read as two bytes, the low byte first and then the high byte. Software can also issue a latch command, which freezes a copy of the count so that a two-byte read stays consistent while the counter keeps running.

The counter steps once for each cycle in which the count-enable strobe is high. In the system this strobe runs at 1,193,180 Hz. Three counting modes are supported: interrupt on terminal count, rate generator and square wave. BCD counting, the read-back command and single-byte access are not supported. A control byte that asks for any of them raises a one-cycle error flag and changes nothing.

The parameter `CHAN_ID` selects which of the three channel numbers this instance answers to. Control bytes addressed to the other two channels leave this instance unchanged.

Top module: `itmr_channel`

## Requirements
- R1: After a synchronous reset, the output is low, the error flag is low, the count is 0, both byte pointers point at the low byte, no latch is pending and the mode is terminal-count.
- R2: A control byte is decoded as follows: bits 7:6 select the channel, bits 5:4 give the access type (0 = latch, 3 = low byte then high byte), bits 3:1 give the mode (0 = terminal count, 2 = rate generator, 3 = square wave) and bit 0 requests BCD. A byte whose channel field differs from `CHAN_ID` and is not 3 has no effect.
- R3: A latch command copies the live count into a holding register and points the read pointer at the low byte. A further latch command issued while a latch is pending is ignored, and the held value does not change.
- R4: Successive reads return the low byte and then the high byte, in turn. While a latch is pending, reads return the held value, and the read of the high byte releases the latch.
- R5: With no latch pending, reads return the live count, still low byte first and then high byte.
- R6: Writing the low byte replaces bits 7:0 of the count, stops counting and drives the output low.
- R7: Writing the high byte completes the 16-bit value and stores it as the period. Counting starts only when that value is nonzero. A zero value leaves the channel stopped with the output low.
- R8: In terminal-count mode, the count falls by one per strobe. On the strobe that takes the count from 1 to 0, the output goes high and counting stops, with the count held at 0.
- R9: In rate-generator mode, the output is high whenever counting starts with a period other than 1. The output is low during the tick in which the count equals 1. On the next strobe the count reloads the period and the output returns high.
- R10: In square-wave mode, the count is loaded with half the period (rounded down, at least 1). The output starts high. Each time the count expires, the output toggles and the count reloads that half period.
- R11: An error is flagged, high for exactly the one cycle after the control write, in any of these cases: a channel field of 3; for this channel, an access type of 1 or 2; a mode other than 0, 2 or 3; or the BCD bit set. The stored mode is left unchanged.
- R12: A latch command in the same cycle as a strobe captures the count as it was before that strobe. A data write in the same cycle as a strobe takes effect, and that strobe is dropped.
- R13: The count does not change in cycles where the count-enable strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable strobe, one count step per high cycle |
| ctrl_we | input | 1 | Write strobe for the shared control byte |
| ctrl_data | input | 8 | Control byte |
| data_we | input | 1 | Write strobe for the data port |
| data_re | input | 1 | Read strobe for the data port; the read pointer advances at the clock edge |
| wr_data | input | 8 | Byte written to the data port |
| rd_data | output | 8 | Byte selected by the read pointer, valid while data_re is high |
| tmr_out | output | 1 | Timer output |
| cfg_err | output | 1 | One-cycle flag for a control byte that requests an unsupported option |

## Verification
The count-enable strobe is independent of the control and data ports, so a tick can fall in the same cycle as a latch command or as a byte write. The bench raises `cnt_en` together with `ctrl_we` for a latch, then reads back the held value and the live value. It expects the held value to be the count from before the tick, and the live value to be one lower. It also writes the low byte and the high byte while the strobe is high, and expects the reloaded count to carry no decrement.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam logic [1:0] SEL_READBACK = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        MODE_TC    = 3'd0,
        MODE_SHOT  = 3'd1,
        MODE_RATE  = 3'd2,
        MODE_SQW   = 3'd3,
        MODE_SSTB  = 3'd4,
        MODE_HSTB  = 3'd5,
        MODE_RATE2 = 3'd6,
        MODE_SQW2  = 3'd7
    } mode_e;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        mode_e      mode;
        logic       bcd;
    } ctrl_word_t;

    function automatic logic mode_ok(input mode_e m);
        return (m == MODE_TC) || (m == MODE_RATE) || (m == MODE_SQW);
    endfunction

    function automatic logic [CNT_W-1:0] sqw_half(input logic [CNT_W-1:0] p);
        logic [CNT_W-1:0] h;
        h = p >> 1;
        return (h == '0) ? CNT_W'(1) : h;
    endfunction

endpackage

// File: rtl/itmr_ctrl_dec.sv
module itmr_ctrl_dec
    import itmr_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_data,
    output logic       latch_req,
    output logic       prog_req,
    output mode_e      prog_mode,
    output logic       cfg_err
);

    ctrl_word_t word;
    logic       bad;

    always_comb begin
        word      = ctrl_word_t'(ctrl_data);
        latch_req = 1'b0;
        prog_req  = 1'b0;
        prog_mode = MODE_TC;
        bad       = 1'b0;
        if (ctrl_we) begin
            if (word.sel == SEL_READBACK) begin
                bad = 1'b1;
            end else if (word.sel == CHAN_ID) begin
                if (word.acc == ACC_LATCH) begin
                    latch_req = 1'b1;
                end else if (word.acc != ACC_LOHI || !mode_ok(word.mode) || word.bcd) begin
                    bad = 1'b1;
                end else begin
                    prog_req  = 1'b1;
                    prog_mode = word.mode;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= bad;
    end

    // R11: a read-back request is always refused
    p_readback_err_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_data[7:6] == SEL_READBACK) |=> cfg_err);

endmodule

// File: rtl/itmr_readport.sv
module itmr_readport
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_req,
    input  logic              data_re,
    input  logic [CNT_W-1:0]  live,
    output logic [BYTE_W-1:0] rd_data
);

    logic [CNT_W-1:0] held;
    logic             held_valid;
    ptr_e             rd_ptr;
    logic [CNT_W-1:0] src;

    always_comb begin
        src     = held_valid ? held : live;
        rd_data = (rd_ptr == PTR_HI) ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= '0;
            held_valid <= 1'b0;
            rd_ptr     <= PTR_LO;
        end else if (latch_req && !held_valid) begin
            held       <= live;
            held_valid <= 1'b1;
            rd_ptr     <= PTR_LO;
        end else if (data_re) begin
            if (rd_ptr == PTR_HI) begin
                rd_ptr     <= PTR_LO;
                held_valid <= 1'b0;
            end else begin
                rd_ptr <= PTR_HI;
            end
        end
    end

    // R3: a pending latch keeps its value until it is read out
    p_hold_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (held_valid && !data_re) |=> (held_valid && $stable(held)));

    // R4: the high-byte read frees the latch
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (held_valid && data_re && rd_ptr == PTR_HI) |=> !held_valid);

endmodule

// File: rtl/itmr_core.sv
module itmr_core
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              prog_req,
    input  mode_e             prog_mode,
    output logic [CNT_W-1:0]  count,
    output logic              tmr_out,
    output mode_e             mode_q
);

    logic [CNT_W-1:0] period;
    logic             running;
    ptr_e             wr_ptr;
    logic [CNT_W-1:0] full;

    assign full = {wr_data, count[BYTE_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            period  <= '0;
            running <= 1'b0;
            tmr_out <= 1'b0;
            mode_q  <= MODE_TC;
            wr_ptr  <= PTR_LO;
        end else begin
            if (prog_req) mode_q <= prog_mode;
            if (data_we) begin
                if (wr_ptr == PTR_LO) begin
                    count[BYTE_W-1:0] <= wr_data;
                    running           <= 1'b0;
                    tmr_out           <= 1'b0;
                    wr_ptr            <= PTR_HI;
                end else begin
                    period <= full;
                    wr_ptr <= PTR_LO;
                    count  <= full;
                    if (full != '0) begin
                        running <= 1'b1;
                        case (mode_q)
                            MODE_SQW: begin
                                count   <= sqw_half(full);
                                tmr_out <= 1'b1;
                            end
                            MODE_RATE: tmr_out <= (full != CNT_W'(1));
                            default:   tmr_out <= 1'b0;
                        endcase
                    end
                end
            end else if (running && cnt_en) begin
                case (mode_q)
                    MODE_RATE: begin
                        if (count == CNT_W'(1)) begin
                            count   <= period;
                            tmr_out <= (period != CNT_W'(1));
                        end else begin
                            count   <= count - 1'b1;
                            tmr_out <= (count != CNT_W'(2));
                        end
                    end
                    MODE_SQW: begin
                        if (count == CNT_W'(1)) begin
                            count   <= sqw_half(period);
                            tmr_out <= ~tmr_out;
                        end else begin
                            count <= count - 1'b1;
                        end
                    end
                    default: begin
                        if (count == CNT_W'(1)) begin
                            count   <= '0;
                            tmr_out <= 1'b1;
                            running <= 1'b0;
                        end else begin
                            count <= count - 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R6: the low-byte write halts the channel and clears the output
    p_lowwr_stops_r6: assert property (@(posedge clk) disable iff (rst)
        (data_we && wr_ptr == PTR_LO) |=> (!running && !tmr_out));

    // R13: no strobe and no write, no change of count
    p_no_tick_r13: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !data_we) |=> $stable(count));

    // R8: terminal count in mode 0 raises the output and stops
    p_tc_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (running && mode_q == MODE_TC && count == CNT_W'(1) && cnt_en && !data_we)
        |=> (tmr_out && !running && count == '0));

    // R7: a zero period leaves the channel idle
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (data_we && wr_ptr == PTR_HI && full == '0) |=> !running);

endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
    import itmr_pkg::*;
#(
    parameter logic [1:0] CHAN_ID = 2'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_data,
    input  logic       data_we,
    input  logic       data_re,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       tmr_out,
    output logic       cfg_err
);

    logic             latch_req;
    logic             prog_req;
    mode_e            prog_mode;
    mode_e            mode_q;
    logic [CNT_W-1:0] count;

    itmr_ctrl_dec #(.CHAN_ID(CHAN_ID)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .ctrl_data (ctrl_data),
        .latch_req (latch_req),
        .prog_req  (prog_req),
        .prog_mode (prog_mode),
        .cfg_err   (cfg_err)
    );

    itmr_core u_core (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .data_we   (data_we),
        .wr_data   (wr_data),
        .prog_req  (prog_req),
        .prog_mode (prog_mode),
        .count     (count),
        .tmr_out   (tmr_out),
        .mode_q    (mode_q)
    );

    itmr_readport u_rd (
        .clk       (clk),
        .rst       (rst),
        .latch_req (latch_req),
        .data_re   (data_re),
        .live      (count),
        .rd_data   (rd_data)
    );

    // R11: a refused control byte leaves the mode untouched
    p_err_mode_kept_r11: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $stable(mode_q));

endmodule

// File: tb/itmr_channel_bench.sv
module itmr_channel_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_data = 8'h00;
    logic       data_we = 1'b0;
    logic       data_re = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tmr_out;
    logic       cfg_err;

    itmr_channel u_itmr_channel (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ctrl_we(ctrl_we),
        .ctrl_data(ctrl_data), .data_we(data_we), .data_re(data_re),
        .wr_data(wr_data), .rd_data(rd_data), .tmr_out(tmr_out),
        .cfg_err(cfg_err)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int         kind;   // 0 read byte, 1 output, 2 error flag
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    logic  done   = 1'b0;

    // monitor: compares a quarter period after each falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = rd_data;
                1:       act = {7'd0, tmr_out};
                default: act = {7'd0, cfg_err};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: kind %0d actual %02h expected %02h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int k, input logic [7:0] e, input string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic ctrl(input logic [7:0] b, input logic tk);
        ctrl_we = 1'b1; ctrl_data = b; cnt_en = tk;
        cyc();
        ctrl_we = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b, input logic tk);
        data_we = 1'b1; wr_data = b; cnt_en = tk;
        cyc();
        data_we = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(v[7:0], 1'b0);
        wr(v[15:8], 1'b0);
    endtask

    task automatic rd(input logic [7:0] e, input string t);
        data_re = 1'b1;
        push(0, e, t);
        cyc();
        data_re = 1'b0;
    endtask

    task automatic rd16(input logic [15:0] e, input string t);
        rd(e[7:0], t);
        rd(e[15:8], t);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_en = 1'b1;
            cyc();
        end
        cnt_en = 1'b0;
    endtask

    task automatic chk_out(input logic v, input string t); push(1, {7'd0, v}, t); endtask
    task automatic chk_err(input logic v, input string t); push(2, {7'd0, v}, t); endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk_out(1'b0, "R1 out"); chk_err(1'b0, "R1 err");
        rd16(16'h0000, "R1 count");

        // R8 terminal count mode
        ctrl(8'h30, 1'b0); chk_err(1'b0, "R2 good word");
        load(16'h0005); chk_out(1'b0, "R7 mode0 start");
        rd16(16'h0005, "R5 live read");
        tick(3); rd16(16'h0002, "R5 live after ticks");
        tick(1); chk_out(1'b0, "R8 before tc");
        tick(1); chk_out(1'b1, "R8 at tc");
        tick(2); rd16(16'h0000, "R8 held at zero"); chk_out(1'b1, "R8 stays high");

        // R6 low byte write
        wr(8'h10, 1'b0); chk_out(1'b0, "R6 out low");
        rd16(16'h0010, "R6 low byte replaced");
        tick(3); rd16(16'h0010, "R6 halted");
        wr(8'h00, 1'b0);

        // R3 / R4 latch
        ctrl(8'h00, 1'b0); tick(4);
        ctrl(8'h00, 1'b0); tick(2);
        rd16(16'h0010, "R3 latched value");
        rd16(16'h000A, "R4 released to live");

        // R2 words for another channel
        ctrl(8'h40, 1'b0); tick(1);
        rd16(16'h0009, "R2 other channel latch ignored");
        ctrl(8'h74, 1'b0); chk_err(1'b0, "R2 other channel program");

        // R12 collisions
        ctrl(8'h00, 1'b1);
        rd16(16'h0009, "R12 latch takes pre-tick count");
        rd16(16'h0008, "R12 live after tick");
        wr(8'h03, 1'b1); wr(8'h00, 1'b1);
        rd16(16'h0003, "R12 write beats tick");
        tick(2); chk_out(1'b0, "R8 count 1");
        tick(1); chk_out(1'b1, "R8 second tc");

        // R13 idle strobe
        load(16'h0100); repeat (5) cyc();
        rd16(16'h0100, "R13 no strobe no count");

        // R7 zero period
        load(16'h0000); tick(3);
        rd16(16'h0000, "R7 zero stays"); chk_out(1'b0, "R7 zero out");

        // R9 rate generator
        ctrl(8'h34, 1'b0); load(16'h0004); chk_out(1'b1, "R9 start high");
        tick(1); chk_out(1'b1, "R9 t1");
        tick(1); chk_out(1'b1, "R9 t2");
        tick(1); chk_out(1'b0, "R9 low pulse");
        tick(1); chk_out(1'b1, "R9 reload high");
        rd16(16'h0004, "R9 reloaded period");
        tick(3); chk_out(1'b0, "R9 second pulse");

        // R10 square wave
        ctrl(8'h36, 1'b0); load(16'h0006); chk_out(1'b1, "R10 start high");
        rd16(16'h0003, "R10 half loaded");
        tick(2); chk_out(1'b1, "R10 first half");
        tick(1); chk_out(1'b0, "R10 toggle low");
        tick(3); chk_out(1'b1, "R10 toggle high");

        // R11 errors
        ctrl(8'hC0, 1'b0); chk_err(1'b1, "R11 readback");
        cyc(); chk_err(1'b0, "R11 one cycle");
        ctrl(8'h10, 1'b0); chk_err(1'b1, "R11 low-only access");
        ctrl(8'h32, 1'b0); chk_err(1'b1, "R11 mode 1");
        ctrl(8'h31, 1'b0); chk_err(1'b1, "R11 bcd");
        load(16'h0004);
        rd16(16'h0002, "R11 mode kept square wave");

        cyc(); cyc();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule